// File: doc/BRIEF.md
# Queue Transfer Result Evaluator

This block does the bookkeeping that follows one bus transaction on a USB host queue element. Each cycle in which `txn_valid` is high, it takes the current overlay of the queue head and the outcome of the transaction. The overlay holds the active and halted flags, the error counter, the data toggle, the NAK reload value and count, the bytes remaining, the page index and the byte offset. The outcome holds the response class, the byte count the device returned, the error kind and the device speed. From these it computes the updated overlay.

One clock later the block presents the result. The result holds the new overlay, a completion flag (Active cleared by this transaction), a short-packet flag for the queue-advance step and a halt indication. It also raises a write-back request, with a mask that names the overlay fields memory must receive.

The block reads no memory and walks no schedule. A memory agent consumes the write-back request and its mask. The split-transaction fields are not stored here: the mask only marks them for the agent.

Top module: `qxfer_eval`

## Requirements
- R1: The result appears on the outputs on the clock edge that follows an edge where `txn_valid` was sampled high. `res_valid` is high for exactly that one cycle. After reset, `res_valid`, `wb_req`, `wb_mask` and all overlay outputs are zero.
- R2: Response code 0 (data or ACK) on an OUT (`txn_is_in`=0) moves min(`ep_max_pkt`, `ov_bytes`) bytes. `res_bytes` drops by that amount, `res_toggle` inverts and `res_nak_cnt` is loaded from `ov_nak_rl`.
- R3: A good IN (response 0, `txn_rx_bytes` not above the expected count) moves `txn_rx_bytes` bytes. If that is below `ep_max_pkt`, then `res_short`=1, `res_active`=0 and `res_done`=1.
- R4: After a good data transaction, the offset advances by the bytes moved, modulo 4096. When the sum reaches 4096 or more, `res_page` increments by one.
- R5: Response code 3 (transaction error) leaves bytes, offset, page and toggle unchanged, decrements `res_cerr` by one and copies `txn_err_kind` into `res_status[1:0]`. If the counter becomes zero, then `res_halted`=1, `res_active`=0 and `res_done`=1.
- R6: Response code 2 (STALL) sets `res_halted`, clears `res_active`, sets `res_done` and `res_status[3]`, and leaves the transfer state unchanged.
- R7: After a good transaction that leaves zero bytes remaining, `res_active`=0, `res_done`=1 and `res_halted`=0. This includes a transfer that began at zero bytes.
- R8: An IN with response 0 whose `txn_rx_bytes` exceeds min(`ep_max_pkt`, `ov_bytes`) is babble. It sets `res_halted`, clears `res_active`, sets `res_status[2]` and leaves the transfer state, toggle and NAK count unchanged.
- R9: Response code 1 (NAK) leaves the transfer state unchanged and decrements `res_nak_cnt`, stopping at zero. `wb_req` is raised only when `ov_nak_rl` is nonzero. Every other outcome on an active overlay raises `wb_req`.
- R10: The `wb_mask` bits are, from bit 0 upward: NAK count, toggle, bytes, page, status, error counter, offset, split progress mask, frame tag, split byte count. A high-speed write-back (`txn_low_full`=0) gives 0x07F and a low- or full-speed one gives 0x3FF. The mask is 0 when `wb_req` is 0.
- R11: A halting outcome wins over normal completion: it gives `res_halted`=1 and `res_short`=0, even when zero bytes remain. A short IN that also empties the transfer gives `res_done`=1, `res_short`=1 and `res_halted`=0.
- R12: With `ov_active`=0, the outcome is ignored. The overlay outputs equal the inputs, `res_done`=0, `res_short`=0 and `wb_req`=0, while `res_valid` still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| txn_valid | input | 1 | Outcome and overlay present for evaluation |
| txn_is_in | input | 1 | 1 = IN transaction, 0 = OUT |
| txn_resp | input | 2 | 0 data/ACK, 1 NAK, 2 STALL, 3 transaction error |
| txn_err_kind | input | 2 | Error kind recorded on a transaction error |
| txn_rx_bytes | input | 12 | Bytes the device sent on an IN |
| txn_low_full | input | 1 | 1 = low- or full-speed device |
| ep_max_pkt | input | 11 | Maximum packet length |
| ov_active | input | 1 | Overlay Active flag |
| ov_halted | input | 1 | Overlay Halted flag |
| ov_cerr | input | 2 | Error counter |
| ov_toggle | input | 1 | Data toggle |
| ov_nak_rl | input | 4 | NAK reload value |
| ov_nak_cnt | input | 4 | NAK count |
| ov_bytes | input | 15 | Bytes remaining |
| ov_page | input | 3 | Current page index |
| ov_offset | input | 12 | Current byte offset in page |
| ov_status | input | 4 | Overlay status bits |
| res_valid | output | 1 | Result valid pulse |
| res_active | output | 1 | Updated Active flag |
| res_halted | output | 1 | Updated Halted flag |
| res_done | output | 1 | Active cleared by this transaction |
| res_short | output | 1 | Short-packet condition |
| res_cerr | output | 2 | Updated error counter |
| res_toggle | output | 1 | Updated data toggle |
| res_nak_cnt | output | 4 | Updated NAK count |
| res_bytes | output | 15 | Updated bytes remaining |
| res_page | output | 3 | Updated page index |
| res_offset | output | 12 | Updated offset |
| res_status | output | 4 | Updated status bits |
| wb_req | output | 1 | Write-back request |
| wb_mask | output | 10 | Fields carried by the write-back |

## Verification
Short-packet detection and zero-remaining completion can both fire on the same IN. The bench provokes this by sending exactly the remaining byte count when that count is below the packet length. It then requires done and short together, with no halt. A halting response can also coincide with a transfer that has zero bytes left. That case is provoked with a STALL on an empty OUT and judged by halted set, short clear and the byte count untouched.

// File: rtl/qxe_pkg.sv
package qxe_pkg;
    typedef enum logic [1:0] {
        RSP_OK    = 2'd0,
        RSP_NAK   = 2'd1,
        RSP_STALL = 2'd2,
        RSP_XERR  = 2'd3
    } rsp_e;

    localparam int ST_W         = 4;
    localparam int ST_BABBLE    = 2;
    localparam int ST_STALL     = 3;
    localparam int WB_FIELDS    = 10;
    localparam int WB_HS_FIELDS = 7;
endpackage

// File: rtl/qxe_size.sv
module qxe_size #(
    parameter int LEN_W = 15,
    parameter int MPL_W = 11,
    parameter int RX_W  = MPL_W + 1
) (
    input  logic [LEN_W-1:0] bytes_left,
    input  logic [MPL_W-1:0] max_pkt,
    input  logic             is_in,
    input  logic [RX_W-1:0]  rx_bytes,
    output logic [MPL_W-1:0] moved,
    output logic             babble,
    output logic             short_pkt
);
    logic [LEN_W-1:0] mpl_ext;
    logic [LEN_W-1:0] expect_len;
    logic [LEN_W-1:0] rx_ext;

    assign mpl_ext    = LEN_W'(max_pkt);
    assign rx_ext     = LEN_W'(rx_bytes);
    assign expect_len = (bytes_left < mpl_ext) ? bytes_left : mpl_ext;
    assign babble     = is_in && (rx_ext > expect_len);
    assign moved      = is_in ? rx_bytes[MPL_W-1:0] : expect_len[MPL_W-1:0];
    assign short_pkt  = is_in && !babble && (moved < max_pkt);
endmodule

// File: rtl/qxe_addr.sv
module qxe_addr #(
    parameter int OFF_W = 12,
    parameter int PG_W  = 3,
    parameter int MPL_W = 11
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [PG_W-1:0]  page,
    input  logic [MPL_W-1:0] moved,
    output logic [OFF_W-1:0] offset_nxt,
    output logic [PG_W-1:0]  page_nxt
);
    logic [OFF_W:0] sum;

    assign sum        = {1'b0, offset} + (OFF_W+1)'(moved);
    assign offset_nxt = sum[OFF_W-1:0];
    assign page_nxt   = page + PG_W'(sum[OFF_W]);
endmodule

// File: rtl/qxe_wbmask.sv
module qxe_wbmask #(
    parameter int NF  = 10,
    parameter int NHS = 7
) (
    input  logic          req,
    input  logic          low_full,
    output logic [NF-1:0] mask
);
    for (genvar i = 0; i < NF; i++) begin : g_field
        if (i < NHS) begin : g_always
            assign mask[i] = req;
        end else begin : g_split
            assign mask[i] = req && low_full;
        end
    end
endmodule

// File: rtl/qxfer_eval.sv
module qxfer_eval
    import qxe_pkg::*;
#(
    parameter int LEN_W  = 15,
    parameter int MPL_W  = 11,
    parameter int RX_W   = MPL_W + 1,
    parameter int OFF_W  = 12,
    parameter int PG_W   = 3,
    parameter int CERR_W = 2,
    parameter int NAK_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 txn_valid,
    input  logic                 txn_is_in,
    input  logic [1:0]           txn_resp,
    input  logic [1:0]           txn_err_kind,
    input  logic [RX_W-1:0]      txn_rx_bytes,
    input  logic                 txn_low_full,
    input  logic [MPL_W-1:0]     ep_max_pkt,
    input  logic                 ov_active,
    input  logic                 ov_halted,
    input  logic [CERR_W-1:0]    ov_cerr,
    input  logic                 ov_toggle,
    input  logic [NAK_W-1:0]     ov_nak_rl,
    input  logic [NAK_W-1:0]     ov_nak_cnt,
    input  logic [LEN_W-1:0]     ov_bytes,
    input  logic [PG_W-1:0]      ov_page,
    input  logic [OFF_W-1:0]     ov_offset,
    input  logic [ST_W-1:0]      ov_status,
    output logic                 res_valid,
    output logic                 res_active,
    output logic                 res_halted,
    output logic                 res_done,
    output logic                 res_short,
    output logic [CERR_W-1:0]    res_cerr,
    output logic                 res_toggle,
    output logic [NAK_W-1:0]     res_nak_cnt,
    output logic [LEN_W-1:0]     res_bytes,
    output logic [PG_W-1:0]      res_page,
    output logic [OFF_W-1:0]     res_offset,
    output logic [ST_W-1:0]      res_status,
    output logic                 wb_req,
    output logic [WB_FIELDS-1:0] wb_mask
);
    typedef struct packed {
        logic                 valid;
        logic                 active;
        logic                 halted;
        logic                 done;
        logic                 short_pkt;
        logic [CERR_W-1:0]    cerr;
        logic                 toggle;
        logic [NAK_W-1:0]     nak_cnt;
        logic [LEN_W-1:0]     bytes;
        logic [PG_W-1:0]      page;
        logic [OFF_W-1:0]     offset;
        logic [ST_W-1:0]      status;
        logic                 wb;
        logic [WB_FIELDS-1:0] mask;
    } res_t;

    res_t st_d, st_q;

    logic [MPL_W-1:0]     moved;
    logic                 babble;
    logic                 short_pkt;
    logic [OFF_W-1:0]     offset_adv;
    logic [PG_W-1:0]      page_adv;
    logic [LEN_W-1:0]     bytes_after;
    logic [CERR_W-1:0]    cerr_dec;
    logic                 wb_d;
    logic [WB_FIELDS-1:0] mask_d;
    rsp_e                 rsp;

    assign rsp         = rsp_e'(txn_resp);
    assign bytes_after = ov_bytes - LEN_W'(moved);
    assign cerr_dec    = (ov_cerr != '0) ? ov_cerr - CERR_W'(1) : '0;

    qxe_size #(.LEN_W(LEN_W), .MPL_W(MPL_W), .RX_W(RX_W)) u_size (
        .bytes_left (ov_bytes),
        .max_pkt    (ep_max_pkt),
        .is_in      (txn_is_in),
        .rx_bytes   (txn_rx_bytes),
        .moved      (moved),
        .babble     (babble),
        .short_pkt  (short_pkt)
    );

    qxe_addr #(.OFF_W(OFF_W), .PG_W(PG_W), .MPL_W(MPL_W)) u_addr (
        .offset     (ov_offset),
        .page       (ov_page),
        .moved      (moved),
        .offset_nxt (offset_adv),
        .page_nxt   (page_adv)
    );

    always_comb begin
        wb_d = txn_valid && ov_active && !(rsp == RSP_NAK && ov_nak_rl == '0);
    end

    qxe_wbmask #(.NF(WB_FIELDS), .NHS(WB_HS_FIELDS)) u_mask (
        .req      (wb_d),
        .low_full (txn_low_full),
        .mask     (mask_d)
    );

    always_comb begin
        st_d           = st_q;
        st_d.valid     = 1'b0;
        st_d.done      = 1'b0;
        st_d.short_pkt = 1'b0;
        st_d.wb        = wb_d;
        st_d.mask      = mask_d;
        if (txn_valid) begin
            st_d.valid   = 1'b1;
            st_d.active  = ov_active;
            st_d.halted  = ov_halted;
            st_d.cerr    = ov_cerr;
            st_d.toggle  = ov_toggle;
            st_d.nak_cnt = ov_nak_cnt;
            st_d.bytes   = ov_bytes;
            st_d.page    = ov_page;
            st_d.offset  = ov_offset;
            st_d.status  = ov_status;
            if (ov_active) begin
                unique case (rsp)
                    RSP_XERR: begin
                        st_d.cerr        = cerr_dec;
                        st_d.status[1:0] = txn_err_kind;
                        if (cerr_dec == '0) begin
                            st_d.halted = 1'b1;
                            st_d.active = 1'b0;
                            st_d.done   = 1'b1;
                        end
                    end
                    RSP_STALL: begin
                        st_d.halted           = 1'b1;
                        st_d.active           = 1'b0;
                        st_d.done             = 1'b1;
                        st_d.status[ST_STALL] = 1'b1;
                    end
                    RSP_NAK: begin
                        if (ov_nak_cnt != '0) begin
                            st_d.nak_cnt = ov_nak_cnt - NAK_W'(1);
                        end
                    end
                    default: begin
                        if (babble) begin
                            st_d.halted            = 1'b1;
                            st_d.active            = 1'b0;
                            st_d.done              = 1'b1;
                            st_d.status[ST_BABBLE] = 1'b1;
                        end else begin
                            st_d.bytes   = bytes_after;
                            st_d.toggle  = !ov_toggle;
                            st_d.offset  = offset_adv;
                            st_d.page    = page_adv;
                            st_d.nak_cnt = ov_nak_rl;
                            if (bytes_after == '0 || short_pkt) begin
                                st_d.active = 1'b0;
                                st_d.done   = 1'b1;
                            end
                            st_d.short_pkt = short_pkt;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid   = st_q.valid;
    assign res_active  = st_q.active;
    assign res_halted  = st_q.halted;
    assign res_done    = st_q.done;
    assign res_short   = st_q.short_pkt;
    assign res_cerr    = st_q.cerr;
    assign res_toggle  = st_q.toggle;
    assign res_nak_cnt = st_q.nak_cnt;
    assign res_bytes   = st_q.bytes;
    assign res_page    = st_q.page;
    assign res_offset  = st_q.offset;
    assign res_status  = st_q.status;
    assign wb_req      = st_q.wb;
    assign wb_mask     = st_q.mask;
endmodule

// File: rtl/qxfer_eval_chk.sv
module qxfer_eval_chk #(
    parameter int LEN_W  = 15,
    parameter int CERR_W = 2,
    parameter int NAK_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              txn_valid,
    input logic [1:0]        txn_resp,
    input logic              ov_active,
    input logic              ov_halted,
    input logic [CERR_W-1:0] ov_cerr,
    input logic [NAK_W-1:0]  ov_nak_rl,
    input logic [LEN_W-1:0]  ov_bytes,
    input logic              res_valid,
    input logic              res_active,
    input logic              res_halted,
    input logic              res_done,
    input logic              res_short,
    input logic [CERR_W-1:0] res_cerr,
    input logic [LEN_W-1:0]  res_bytes,
    input logic              wb_req
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(txn_valid)); // R1
    AST_BYTES_NOT_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_bytes <= $past(ov_bytes)); // R2
    AST_ERR_CERR_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        $past(txn_valid && ov_active && txn_resp == 2'd3 && ov_cerr != '0)
        |-> res_cerr == $past(ov_cerr) - CERR_W'(1)); // R5
    AST_ERR_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(txn_valid && ov_active && txn_resp == 2'd3)
        |-> res_bytes == $past(ov_bytes)); // R5
    AST_HALT_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_halted && !$past(ov_halted) |-> !res_active); // R6
    AST_NAK_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        $past(txn_valid && ov_active && txn_resp == 2'd1 && ov_nak_rl == '0)
        |-> !wb_req); // R9
    AST_DONE_WB: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |-> wb_req); // R9
    AST_SHORT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        res_short |-> res_done && !res_active); // R3
endmodule

bind qxfer_eval qxfer_eval_chk #(.LEN_W(LEN_W), .CERR_W(CERR_W), .NAK_W(NAK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .txn_valid  (txn_valid),
    .txn_resp   (txn_resp),
    .ov_active  (ov_active),
    .ov_halted  (ov_halted),
    .ov_cerr    (ov_cerr),
    .ov_nak_rl  (ov_nak_rl),
    .ov_bytes   (ov_bytes),
    .res_valid  (res_valid),
    .res_active (res_active),
    .res_halted (res_halted),
    .res_done   (res_done),
    .res_short  (res_short),
    .res_cerr   (res_cerr),
    .res_bytes  (res_bytes),
    .wb_req     (wb_req)
);

// File: tb/qxfer_eval_tb.sv
module qxfer_eval_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txn_valid = 1'b0;
    logic        txn_is_in = 1'b0;
    logic [1:0]  txn_resp = '0;
    logic [1:0]  txn_err_kind = '0;
    logic [11:0] txn_rx_bytes = '0;
    logic        txn_low_full = 1'b0;
    logic [10:0] ep_max_pkt = '0;
    logic        ov_active = 1'b0;
    logic        ov_halted = 1'b0;
    logic [1:0]  ov_cerr = '0;
    logic        ov_toggle = 1'b0;
    logic [3:0]  ov_nak_rl = '0;
    logic [3:0]  ov_nak_cnt = '0;
    logic [14:0] ov_bytes = '0;
    logic [2:0]  ov_page = '0;
    logic [11:0] ov_offset = '0;
    logic [3:0]  ov_status = '0;
    logic        res_valid, res_active, res_halted, res_done, res_short;
    logic [1:0]  res_cerr;
    logic        res_toggle;
    logic [3:0]  res_nak_cnt;
    logic [14:0] res_bytes;
    logic [2:0]  res_page;
    logic [11:0] res_offset;
    logic [3:0]  res_status;
    logic        wb_req;
    logic [9:0]  wb_mask;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    qxfer_eval u_dut (
        .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_is_in(txn_is_in),
        .txn_resp(txn_resp), .txn_err_kind(txn_err_kind), .txn_rx_bytes(txn_rx_bytes),
        .txn_low_full(txn_low_full), .ep_max_pkt(ep_max_pkt), .ov_active(ov_active),
        .ov_halted(ov_halted), .ov_cerr(ov_cerr), .ov_toggle(ov_toggle),
        .ov_nak_rl(ov_nak_rl), .ov_nak_cnt(ov_nak_cnt), .ov_bytes(ov_bytes),
        .ov_page(ov_page), .ov_offset(ov_offset), .ov_status(ov_status),
        .res_valid(res_valid), .res_active(res_active), .res_halted(res_halted),
        .res_done(res_done), .res_short(res_short), .res_cerr(res_cerr),
        .res_toggle(res_toggle), .res_nak_cnt(res_nak_cnt), .res_bytes(res_bytes),
        .res_page(res_page), .res_offset(res_offset), .res_status(res_status),
        .wb_req(wb_req), .wb_mask(wb_mask)
    );

    typedef struct packed {
        logic        is_in;
        logic [1:0]  rsp;
        logic [1:0]  ek;
        logic        lf;
        logic [14:0] by;
        logic [10:0] mpl;
        logic [11:0] rx;
        logic [11:0] off;
        logic [2:0]  pg;
        logic [1:0]  ce;
        logic [3:0]  rl;
        logic [3:0]  nc;
        logic        tg;
        logic        e_act;
        logic        e_hlt;
        logic        e_done;
        logic        e_short;
        logic [14:0] e_by;
        logic [11:0] e_off;
        logic [2:0]  e_pg;
        logic [1:0]  e_ce;
        logic        e_tg;
        logic [3:0]  e_nc;
        logic        e_wb;
        logic [9:0]  e_mask;
        logic [3:0]  e_st;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        // R2 OUT limited by packet length
        '{1'b0,2'd0,2'd0,1'b0,15'd1000,11'd512,12'd0,12'd100,3'd0,2'd3,4'd5,4'd2,1'b0,
          1'b1,1'b0,1'b0,1'b0,15'd488,12'd612,3'd0,2'd3,1'b1,4'd5,1'b1,10'h07F,4'd0,8'd2},
        // R7 OUT empties transfer, R10 low/full mask
        '{1'b0,2'd0,2'd0,1'b1,15'd100,11'd512,12'd0,12'd0,3'd0,2'd3,4'd0,4'd0,1'b1,
          1'b0,1'b0,1'b1,1'b0,15'd0,12'd100,3'd0,2'd3,1'b0,4'd0,1'b1,10'h3FF,4'd0,8'd7},
        // R4 short IN crossing page, R3
        '{1'b1,2'd0,2'd0,1'b0,15'd1000,11'd512,12'd200,12'd4000,3'd1,2'd3,4'd3,4'd1,1'b0,
          1'b0,1'b0,1'b1,1'b1,15'd800,12'd104,3'd2,2'd3,1'b1,4'd3,1'b1,10'h07F,4'd0,8'd4},
        // R4 OUT landing exactly on 4096
        '{1'b0,2'd0,2'd0,1'b0,15'd2000,11'd96,12'd0,12'd4000,3'd3,2'd3,4'd3,4'd1,1'b1,
          1'b1,1'b0,1'b0,1'b0,15'd1904,12'd0,3'd4,2'd3,1'b0,4'd3,1'b1,10'h07F,4'd0,8'd4},
        // R3 full-size IN keeps Active
        '{1'b1,2'd0,2'd0,1'b0,15'd1024,11'd512,12'd512,12'd0,3'd0,2'd2,4'd1,4'd0,1'b0,
          1'b1,1'b0,1'b0,1'b0,15'd512,12'd512,3'd0,2'd2,1'b1,4'd1,1'b1,10'h07F,4'd0,8'd3},
        // R8 babble beyond packet length
        '{1'b1,2'd0,2'd0,1'b0,15'd1024,11'd512,12'd513,12'd10,3'd0,2'd3,4'd4,4'd2,1'b0,
          1'b0,1'b1,1'b1,1'b0,15'd1024,12'd10,3'd0,2'd3,1'b0,4'd2,1'b1,10'h07F,4'd4,8'd8},
        // R8 babble beyond remaining bytes
        '{1'b1,2'd0,2'd0,1'b1,15'd100,11'd512,12'd101,12'd10,3'd0,2'd3,4'd4,4'd2,1'b0,
          1'b0,1'b1,1'b1,1'b0,15'd100,12'd10,3'd0,2'd3,1'b0,4'd2,1'b1,10'h3FF,4'd4,8'd8},
        // R5 error, counter 3 -> 2
        '{1'b0,2'd3,2'd2,1'b0,15'd1000,11'd512,12'd0,12'd10,3'd0,2'd3,4'd4,4'd2,1'b0,
          1'b1,1'b0,1'b0,1'b0,15'd1000,12'd10,3'd0,2'd2,1'b0,4'd2,1'b1,10'h07F,4'd2,8'd5},
        // R5 error, counter 1 -> 0 halts
        '{1'b1,2'd3,2'd1,1'b0,15'd1000,11'd512,12'd0,12'd10,3'd0,2'd1,4'd4,4'd2,1'b0,
          1'b0,1'b1,1'b1,1'b0,15'd1000,12'd10,3'd0,2'd0,1'b0,4'd2,1'b1,10'h07F,4'd1,8'd5},
        // R6 STALL
        '{1'b0,2'd2,2'd0,1'b1,15'd1000,11'd512,12'd0,12'd10,3'd0,2'd3,4'd4,4'd2,1'b1,
          1'b0,1'b1,1'b1,1'b0,15'd1000,12'd10,3'd0,2'd3,1'b1,4'd2,1'b1,10'h3FF,4'd8,8'd6},
        // R9 NAK, reload zero, no write-back
        '{1'b1,2'd1,2'd0,1'b0,15'd1000,11'd512,12'd0,12'd10,3'd0,2'd3,4'd0,4'd0,1'b0,
          1'b1,1'b0,1'b0,1'b0,15'd1000,12'd10,3'd0,2'd3,1'b0,4'd0,1'b0,10'h000,4'd0,8'd9},
        // R9 NAK counts down
        '{1'b1,2'd1,2'd0,1'b1,15'd1000,11'd512,12'd0,12'd10,3'd0,2'd3,4'd4,4'd3,1'b0,
          1'b1,1'b0,1'b0,1'b0,15'd1000,12'd10,3'd0,2'd3,1'b0,4'd2,1'b1,10'h3FF,4'd0,8'd9},
        // R9 NAK count stops at zero
        '{1'b0,2'd1,2'd0,1'b0,15'd1000,11'd512,12'd0,12'd10,3'd0,2'd3,4'd4,4'd0,1'b0,
          1'b1,1'b0,1'b0,1'b0,15'd1000,12'd10,3'd0,2'd3,1'b0,4'd0,1'b1,10'h07F,4'd0,8'd9},
        // R7 zero-length OUT
        '{1'b0,2'd0,2'd0,1'b0,15'd0,11'd64,12'd0,12'd20,3'd0,2'd3,4'd2,4'd1,1'b0,
          1'b0,1'b0,1'b1,1'b0,15'd0,12'd20,3'd0,2'd3,1'b1,4'd2,1'b1,10'h07F,4'd0,8'd7},
        // R11 short IN that also empties the transfer
        '{1'b1,2'd0,2'd0,1'b0,15'd300,11'd512,12'd300,12'd0,3'd0,2'd3,4'd2,4'd1,1'b1,
          1'b0,1'b0,1'b1,1'b1,15'd0,12'd300,3'd0,2'd3,1'b0,4'd2,1'b1,10'h07F,4'd0,8'd11},
        // R11 STALL on empty transfer: halt wins
        '{1'b0,2'd2,2'd0,1'b0,15'd0,11'd64,12'd0,12'd20,3'd0,2'd3,4'd2,4'd1,1'b0,
          1'b0,1'b1,1'b1,1'b0,15'd0,12'd20,3'd0,2'd3,1'b0,4'd1,1'b1,10'h07F,4'd8,8'd11}
    };

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic one_txn();
        txn_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        txn_valid = 1'b0;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "reset outputs",
              64'({res_valid, wb_req, wb_mask, res_bytes, res_offset, res_active, res_halted}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            txn_is_in = v.is_in; txn_resp = v.rsp; txn_err_kind = v.ek;
            txn_low_full = v.lf; ov_bytes = v.by; ep_max_pkt = v.mpl;
            txn_rx_bytes = v.rx; ov_offset = v.off; ov_page = v.pg;
            ov_cerr = v.ce; ov_nak_rl = v.rl; ov_nak_cnt = v.nc; ov_toggle = v.tg;
            ov_active = 1'b1; ov_halted = 1'b0; ov_status = 4'd0;
            one_txn();
            check($sformatf("R%0d", v.req), $sformatf("vector %0d overlay", i),
                  64'({res_valid, res_active, res_halted, res_done, res_short, res_bytes,
                       res_offset, res_page, res_cerr, res_toggle, res_nak_cnt, res_status}),
                  64'({1'b1, v.e_act, v.e_hlt, v.e_done, v.e_short, v.e_by,
                       v.e_off, v.e_pg, v.e_ce, v.e_tg, v.e_nc, v.e_st}));
            // R10 write-back request and field mask
            check("R10", $sformatf("vector %0d write-back", i),
                  64'({wb_req, wb_mask}), 64'({v.e_wb, v.e_mask}));
        end

        // R1 result pulse lasts one cycle
        @(negedge clk);
        check("R1", "valid drops", 64'({res_valid, wb_req, res_done}), 64'd0);

        // R12 inactive overlay ignores a STALL
        ov_active = 1'b0; ov_halted = 1'b1; txn_resp = 2'd2; txn_is_in = 1'b0;
        ov_bytes = 15'd777; ov_offset = 12'd33; ov_cerr = 2'd2; ov_status = 4'd1;
        ov_nak_cnt = 4'd6; ov_nak_rl = 4'd7; txn_low_full = 1'b1;
        one_txn();
        check("R12", "inactive overlay",
              64'({res_valid, res_active, res_halted, res_done, res_short, res_bytes,
                   res_offset, res_cerr, res_status, res_nak_cnt, wb_req, wb_mask}),
              64'({1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 15'd777,
                   12'd33, 2'd2, 4'd1, 4'd6, 1'b0, 10'h000}));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule